// File: doc/BRIEF.md
# Bit Field Execution Unit

This unit carries out one bit field operation per request on a 64-bit window made of two adjacent 32-bit words. A field is located by a starting position and a length of 1 to 32 bits, so it may sit wholly in the upper word or straddle into the lower one. Eight operations are offered. Two extract the field into a destination register value, zero- or sign-extended. One writes a supplied value into the field. One locates the first set bit. One only tests. Three overwrite the field with ones, with zeros, or with its own complement.

A request is presented with `start` high for one clock. On the next clock edge the unit registers the updated window, the destination value, the write enables and the negative and zero flags, and raises `done` for exactly one cycle. The flags always describe the field as it stood in the input window, before any rewrite. Memory access, alignment on the bus and instruction decoding are left to the surrounding pipeline.

Top module: `bf_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs (`done`, `win_we`, `dest_we`, `flag_n`, `flag_z`, `dest`, `win_out`) become zero after that edge.
- R2: `start` high at an edge makes every output reflect that request after the same edge, with `done` high for that one cycle; an edge without `start` leaves `done`, `win_we` and `dest_we` low, and the two enables are never high together.
- R3: `offset` (0 to 31) counts from window bit 63, which is position 0; `width` code 0 means 32, codes 1 to 31 mean themselves; the field spans window bits 63-offset down to 64-offset-length and may cross from bit 32 into bit 31.
- R4: Opcode 0 (unsigned extract) sets `dest` to the field zero-extended and raises `dest_we`.
- R5: Opcode 1 (signed extract) sets `dest` to the field sign-extended from its most significant bit and raises `dest_we`.
- R6: Opcode 2 (insert) writes the low field-length bits of `ins_val` into the field, with `ins_val` bit 0 landing on the field's least significant bit, and raises `win_we`.
- R7: Opcode 3 (find first set) scans from the field's most significant bit toward its least; `dest` is offset plus the number of zero bits passed before the first one, or offset plus length when the field is all zero; `dest_we` is raised.
- R8: Opcodes 5, 6 and 7 write all ones, all zeros, and the bitwise complement into the field respectively, and raise `win_we`.
- R9: Opcode 4 (test) raises neither enable and returns `win_out` equal to the input window.
- R10: For every opcode, `flag_n` is the field's most significant bit and `flag_z` is high exactly when every field bit is zero, both taken from the input window before the operation.
- R11: Window bits outside the field are returned unchanged in `win_out` for every opcode; `dest` is zero for opcodes that do not raise `dest_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one cycle per operation |
| op | input | 3 | Operation code |
| win_in | input | 64 | Source window, upper word in bits 63:32 |
| offset | input | 5 | Field start, counted from window bit 63 |
| width | input | 5 | Field length code, 0 means 32 |
| ins_val | input | 32 | Value whose low bits are inserted |
| done | output | 1 | One-cycle completion pulse |
| win_out | output | 64 | Window after the operation |
| win_we | output | 1 | Window write-back enable |
| dest | output | 32 | Destination register result |
| dest_we | output | 1 | Destination register write enable |
| flag_n | output | 1 | Field most significant bit before the operation |
| flag_z | output | 1 | Field was all zero before the operation |

## Verification
Flag generation and field rewriting happen in the same cycle, so a faulty unit could derive the flags from the rewritten field instead of the original one. The bench provokes this with insert, complement, set and clear requests on fields whose old most significant bit and zero state differ from those of the new content, including an insert of zero into a nonzero field and an insert of ones into an empty field. The flags are judged against a bench model that reads only the input window, and the rewritten window is judged in the same sample, so either confusion shows up as a mismatch.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam int BF_WORD_W = 32;

    typedef enum logic [2:0] {
        BF_EXTU = 3'd0,
        BF_EXTS = 3'd1,
        BF_INS  = 3'd2,
        BF_FFO  = 3'd3,
        BF_TST  = 3'd4,
        BF_SET  = 3'd5,
        BF_CLR  = 3'd6,
        BF_CHG  = 3'd7
    } bf_op_e;

    typedef struct packed {
        logic n;
        logic z;
    } bf_flags_t;

    function automatic logic op_writes_window(bf_op_e op);
        return (op == BF_INS) || (op == BF_SET) || (op == BF_CLR) || (op == BF_CHG);
    endfunction

    function automatic logic op_writes_dest(bf_op_e op);
        return (op == BF_EXTU) || (op == BF_EXTS) || (op == BF_FFO);
    endfunction

endpackage

// File: rtl/bf_field_align.sv
module bf_field_align #(
    parameter int WORD_W = bf_pkg::BF_WORD_W,
    localparam int WIN_W = 2 * WORD_W,
    localparam int OFS_W = $clog2(WORD_W),
    localparam int CNT_W = OFS_W + 1,
    localparam int POS_W = $clog2(WIN_W)
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [OFS_W-1:0]  wcode,
    output logic [CNT_W-1:0]  weff,
    output logic [POS_W-1:0]  lsb_pos,
    output logic [WIN_W-1:0]  mask,
    output logic [WORD_W-1:0] low_mask,
    output logic [WORD_W-1:0] field,
    output logic              msb
);

    always_comb begin
        weff     = (wcode == '0) ? CNT_W'(WORD_W) : {1'b0, wcode};
        lsb_pos  = POS_W'(WIN_W - int'(ofs) - int'(weff));
        low_mask = {WORD_W{1'b1}} >> (WORD_W - int'(weff));
        mask     = {{WORD_W{1'b0}}, low_mask} << lsb_pos;
        field    = WORD_W'(win >> lsb_pos) & low_mask;
        msb      = |(field & (WORD_W'(1) << (weff - CNT_W'(1))));
    end

endmodule

// File: rtl/bf_lead_scan.sv
module bf_lead_scan #(
    parameter int WORD_W = bf_pkg::BF_WORD_W,
    localparam int OFS_W = $clog2(WORD_W),
    localparam int CNT_W = OFS_W + 1
) (
    input  logic [WORD_W-1:0] field,
    input  logic [CNT_W-1:0]  weff,
    output logic [CNT_W-1:0]  zeros
);

    logic [WORD_W-1:0] left_just;
    logic              hit;

    always_comb begin
        left_just = field << (WORD_W - int'(weff));
        zeros     = weff;
        hit       = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (!hit && left_just[i]) begin
                zeros = CNT_W'(WORD_W - 1 - i);
                hit   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bf_exec_unit.sv
module bf_exec_unit #(
    parameter int WORD_W = bf_pkg::BF_WORD_W,
    localparam int WIN_W = 2 * WORD_W,
    localparam int OFS_W = $clog2(WORD_W),
    localparam int CNT_W = OFS_W + 1,
    localparam int POS_W = $clog2(WIN_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [WIN_W-1:0]  win_in,
    input  logic [OFS_W-1:0]  offset,
    input  logic [OFS_W-1:0]  width,
    input  logic [WORD_W-1:0] ins_val,
    output logic              done,
    output logic [WIN_W-1:0]  win_out,
    output logic              win_we,
    output logic [WORD_W-1:0] dest,
    output logic              dest_we,
    output logic              flag_n,
    output logic              flag_z
);
    import bf_pkg::*;

    bf_op_e            op_e;
    logic [CNT_W-1:0]  fld_weff;
    logic [POS_W-1:0]  fld_lsb;
    logic [WIN_W-1:0]  fld_mask;
    logic [WORD_W-1:0] fld_low_mask;
    logic [WORD_W-1:0] fld_val;
    logic              fld_msb;
    logic [CNT_W-1:0]  fld_zeros;

    logic [WIN_W-1:0]  nxt_win;
    logic [WORD_W-1:0] nxt_dest;
    bf_flags_t         nxt_flags;
    logic [WIN_W-1:0]  ins_placed;

    assign op_e = bf_op_e'(op);

    bf_field_align #(.WORD_W(WORD_W)) u_align (
        .win      (win_in),
        .ofs      (offset),
        .wcode    (width),
        .weff     (fld_weff),
        .lsb_pos  (fld_lsb),
        .mask     (fld_mask),
        .low_mask (fld_low_mask),
        .field    (fld_val),
        .msb      (fld_msb)
    );

    bf_lead_scan #(.WORD_W(WORD_W)) u_scan (
        .field (fld_val),
        .weff  (fld_weff),
        .zeros (fld_zeros)
    );

    always_comb begin
        ins_placed  = {{WORD_W{1'b0}}, ins_val & fld_low_mask} << fld_lsb;
        nxt_flags.n = fld_msb;
        nxt_flags.z = (fld_val == '0);
        nxt_win     = win_in;
        nxt_dest    = '0;
        unique case (op_e)
            BF_EXTU: nxt_dest = fld_val;
            BF_EXTS: nxt_dest = fld_val | (fld_msb ? ~fld_low_mask : '0);
            BF_INS:  nxt_win  = (win_in & ~fld_mask) | ins_placed;
            BF_FFO:  nxt_dest = WORD_W'(offset) + WORD_W'(fld_zeros);
            BF_TST:  nxt_win  = win_in;
            BF_SET:  nxt_win  = win_in | fld_mask;
            BF_CLR:  nxt_win  = win_in & ~fld_mask;
            BF_CHG:  nxt_win  = win_in ^ fld_mask;
            default: nxt_win  = win_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            win_we  <= 1'b0;
            dest_we <= 1'b0;
            win_out <= '0;
            dest    <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
        end else begin
            done    <= start;
            win_we  <= start && op_writes_window(op_e);
            dest_we <= start && op_writes_dest(op_e);
            if (start) begin
                win_out <= nxt_win;
                dest    <= nxt_dest;
                flag_n  <= nxt_flags.n;
                flag_z  <= nxt_flags.z;
            end
        end
    end

endmodule

// File: rtl/bf_exec_unit_chk.sv
module bf_exec_unit_chk #(
    parameter int WORD_W = bf_pkg::BF_WORD_W,
    localparam int WIN_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2:0]        op,
    input logic [WIN_W-1:0]  win_in,
    input logic              done,
    input logic [WIN_W-1:0]  win_out,
    input logic              win_we,
    input logic              dest_we,
    input logic [WORD_W-1:0] dest,
    input logic [WIN_W-1:0]  mask,
    input logic [WORD_W-1:0] low_mask
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!done && !win_we && !dest_we));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!done && !win_we && !dest_we));

    assert_enables_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(win_we && dest_we));

    assert_extu_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd0) |=> (dest_we && ((dest & ~$past(low_mask)) == '0)));

    assert_set_ones_R8: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd5) |=> ((win_out & $past(mask)) == $past(mask)));

    assert_clr_zeros_R8: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd6) |=> ((win_out & $past(mask)) == '0));

    assert_test_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd4) |=> (!win_we && !dest_we && win_out == $past(win_in)));

    assert_outside_kept_R11: assert property (@(posedge clk) disable iff (rst)
        start |=> (((win_out ^ $past(win_in)) & ~$past(mask)) == '0));

endmodule

bind bf_exec_unit bf_exec_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op       (op),
    .win_in   (win_in),
    .done     (done),
    .win_out  (win_out),
    .win_we   (win_we),
    .dest_we  (dest_we),
    .dest     (dest),
    .mask     (fld_mask),
    .low_mask (fld_low_mask)
);

// File: tb/bf_exec_unit_tb.sv
`timescale 1ns/1ps
module bf_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] win_in = '0;
    logic [4:0]  offset = '0;
    logic [4:0]  width = '0;
    logic [31:0] ins_val = '0;
    logic        done, win_we, dest_we, flag_n, flag_z;
    logic [63:0] win_out;
    logic [31:0] dest;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bf_exec_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .win_in(win_in),
        .offset(offset), .width(width), .ins_val(ins_val), .done(done),
        .win_out(win_out), .win_we(win_we), .dest(dest), .dest_we(dest_we),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string op_req(logic [2:0] o);
        case (o)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R9";
            default: return "R8";
        endcase
    endfunction

    // Bit-serial reference model built from the requirements.
    task automatic model(input logic [2:0] o, input logic [63:0] w, input logic [4:0] ofs,
                         input logic [4:0] wc, input logic [31:0] ins,
                         output logic [63:0] ew, output logic [31:0] ed,
                         output logic ewe, output logic edwe, output logic en, output logic ez);
        int len;
        int pos;
        logic [31:0] fv;
        len = (wc == 0) ? 32 : int'(wc);
        fv = '0;
        for (int i = 0; i < len; i++) fv = (fv << 1) | 32'(w[63 - int'(ofs) - i]);
        en = w[63 - int'(ofs)];
        ez = (fv == 0);
        ew = w;
        ed = '0;
        ewe = (o == 3'd2) || (o >= 3'd5);
        edwe = (o <= 3'd1) || (o == 3'd3);
        pos = len;
        for (int i = len - 1; i >= 0; i--) if (w[63 - int'(ofs) - i]) pos = i;
        for (int i = 0; i < len; i++) begin
            int b;
            b = 63 - int'(ofs) - i;
            case (o)
                3'd2: ew[b] = ins[len - 1 - i];
                3'd5: ew[b] = 1'b1;
                3'd6: ew[b] = 1'b0;
                3'd7: ew[b] = ~w[b];
                default: ;
            endcase
        end
        case (o)
            3'd0: ed = fv;
            3'd1: ed = (len < 32 && fv[len - 1]) ? (fv | (32'hFFFF_FFFF << len)) : fv;
            3'd3: ed = 32'(int'(ofs) + pos);
            default: ;
        endcase
    endtask

    task automatic run(string ctx, logic [2:0] o, logic [63:0] w, logic [4:0] ofs,
                       logic [4:0] wc, logic [31:0] ins);
        logic [63:0] ew;
        logic [31:0] ed;
        logic ewe, edwe, en, ez;
        string rq;
        model(o, w, ofs, wc, ins, ew, ed, ewe, edwe, en, ez);
        rq = {op_req(o), ctx};
        @(negedge clk);
        start = 1'b1; op = o; win_in = w; offset = ofs; width = wc; ins_val = ins;
        @(negedge clk);
        start = 1'b0; win_in = ~w; ins_val = ~ins;
        chk("R2", "done", 64'(done), 64'd1);
        chk({rq, "/R11"}, "win_out", win_out, ew);
        chk(rq, "win_we", 64'(win_we), 64'(ewe));
        chk({rq, "/R11"}, "dest", 64'(dest), 64'(ed));
        chk(rq, "dest_we", 64'(dest_we), 64'(edwe));
        chk("R10", "flag_n", 64'(flag_n), 64'(en));
        chk("R10", "flag_z", 64'(flag_z), 64'(ez));
    endtask

    initial begin
        void'($urandom(32'h1B5E_0D42));
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk("R1", "done", 64'(done), 0);
        chk("R1", "win_we", 64'(win_we), 0);
        chk("R1", "dest_we", 64'(dest_we), 0);
        chk("R1", "win_out", win_out, 0);
        chk("R1", "dest", 64'(dest), 0);
        chk("R1", "flags", 64'({flag_n, flag_z}), 0);
        rst = 1'b0;

        // R3 geometry corners: full upper word, cross-word fields, single bits
        run(" R3 full-upper", 3'd0, 64'hDEAD_BEEF_0123_4567, 5'd0, 5'd0, 0);
        run(" R3 cross-max", 3'd0, 64'h8000_0001_8000_0001, 5'd31, 5'd0, 0);
        run(" R3 cross-8", 3'd1, 64'h0000_000F_F000_0000, 5'd28, 5'd8, 0);
        run(" R3 lsb-single", 3'd1, 64'h0000_0001_0000_0000, 5'd31, 5'd1, 0);
        run(" R3 msb-single", 3'd5, 64'h7FFF_FFFF_FFFF_FFFF, 5'd0, 5'd1, 0);
        // find first set corners
        run(" empty", 3'd3, 64'hFFF0_0000_0FFF_FFFF, 5'd12, 5'd16, 0);
        run(" top-hit", 3'd3, 64'h0008_0000_0000_0000, 5'd12, 5'd4, 0);
        run(" last-hit", 3'd3, 64'h0000_0000_0000_0002, 5'd31, 5'd0, 0);
        // flags from old field while rewriting in the same cycle
        run(" zero-into-full", 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 5'd4, 5'd12, 0);
        run(" ones-into-empty", 3'd2, 64'h0, 5'd20, 5'd20, 32'hFFFF_FFFF);
        run(" chg-empty", 3'd7, 64'h0, 5'd3, 5'd7, 0);
        run(" clr-full", 3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 5'd0, 0);
        run(" test", 3'd4, 64'h1234_5678_9ABC_DEF0, 5'd9, 5'd30, 32'hFFFF_FFFF);

        // idle cycle after a request: R2
        @(negedge clk);
        chk("R2", "idle done", 64'(done), 0);
        chk("R2", "idle enables", 64'({win_we, dest_we}), 0);

        for (int k = 0; k < 400; k++) begin
            logic [63:0] w;
            w = {$urandom, $urandom};
            if ($urandom % 3 == 0) w = w & {$urandom, $urandom} & {$urandom, $urandom};
            run(" rnd", 3'($urandom), w, 5'($urandom), 5'($urandom), $urandom);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule